// File: doc/BRIEF.md
# Flash Unlock-Sequence Command Decoder

This block sits behind the bus interface of a parallel NOR flash model or controller. It watches the bus write cycles, each given as a one-clock write strobe with an address and a data word. It recognises the multi-cycle unlock sequences that start every flash command. When a sequence completes, the block raises a one-clock command strobe and presents the address and data captured on the final cycle. The strobes start a chip erase, a sector erase, a word program or a boot-region lock, or they enter or leave identification mode. A downstream operation timer uses these strobes and reports back with a busy flag.

The block also holds the read-array / identification mode flag. In identification mode it returns the manufacturer and device codes for the read address it is given. Several six-cycle sequences share their first five cycles and differ only in the last address and data. A lone write of 0xF0 at any address also leaves identification mode. A write that breaks a sequence sends the decoder back to idle. That write is not checked again as a new first cycle.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Unlock matching compares only address bits 14..0 and data bits 7..0. Set upper bits on unlock cycles do not stop a match.
- R2: Writes of 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555 and then any address/data give a program strobe one cycle after the fourth write. The strobe carries the fourth write's full address and data.
- R3: Writes of 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA and then 0x10@0x5555 give a chip-erase strobe.
- R4: The same five-cycle prefix followed by 0x30 at any address gives a sector-erase strobe. The strobe carries that sixth-cycle address.
- R5: The same five-cycle prefix followed by 0x40@0x5555 gives a boot-lock strobe.
- R6: Writes of 0xAA@0x5555, 0x55@0x2AAA and 0x90@0x5555 give an ID-entry strobe, and the mode flag is set in that same cycle.
- R7: Writes of 0xAA@0x5555, 0x55@0x2AAA and 0xF0@0x5555 give an ID-exit strobe and clear the mode flag.
- R8: From idle, a single write with data 0xF0 at any address gives an ID-exit strobe and clears the mode flag.
- R9: In identification mode, read address 0 returns 0x001F, read address 1 returns 0x0092, and any other address returns 0. Outside identification mode the ID read data is 0.
- R10: Reset clears the mode flag and all strobes, and returns the sequence to idle.
- R11: A write while busy is high is ignored. It gives no strobe and leaves the sequence position unchanged.
- R12: A write that does not match the expected next step returns the sequence to idle. That write is not checked again as a first cycle.
- R13: At most one command strobe is high in any cycle. A strobe follows only a write in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | One-cycle bus write strobe |
| wr_addr_i | input | 18 | Write address |
| wr_data_i | input | 16 | Write data |
| busy_i | input | 1 | Embedded operation in progress |
| rd_addr_i | input | 18 | Read address for ID data |
| cmd_chip_erase_o | output | 1 | Chip erase strobe |
| cmd_sector_erase_o | output | 1 | Sector erase strobe |
| cmd_word_prog_o | output | 1 | Word program strobe |
| cmd_boot_lock_o | output | 1 | Boot-region lock strobe |
| cmd_id_enter_o | output | 1 | ID mode entry strobe |
| cmd_id_exit_o | output | 1 | ID mode exit strobe |
| cmd_addr_o | output | 18 | Address captured with the last strobe |
| cmd_data_o | output | 16 | Data captured with the last strobe |
| id_mode_o | output | 1 | Identification mode active |
| id_data_o | output | 16 | ID read data |

## Verification
The final write of a sequence and the busy flag can fall in the same cycle. To provoke this, the bench raises busy_i on the very write that would complete an ID-entry sequence. The pass condition is that no strobe follows and the mode flag stays clear. The bench then repeats only that final write with busy low, and it must now complete the sequence, which shows the sequence position was held. A second overlap is a lone 0xF0 write landing while the ID codes are being read. The ID data must drop to zero in the same cycle that the exit strobe appears.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG, ST_EXT3, ST_EXT4, ST_EXT5
  } seq_state_e;

  localparam int CMD_N = 6;
  localparam int C_CHIP = 0;
  localparam int C_SECT = 1;
  localparam int C_PROG = 2;
  localparam int C_LOCK = 3;
  localparam int C_IDIN = 4;
  localparam int C_IDOUT = 5;

  localparam int CMP_AW = 15;
  localparam int CMP_DW = 8;

  localparam logic [CMP_AW-1:0] ADR_KEY1 = 15'h5555;
  localparam logic [CMP_AW-1:0] ADR_KEY2 = 15'h2AAA;
  localparam logic [CMP_DW-1:0] DAT_KEY1 = 8'hAA;
  localparam logic [CMP_DW-1:0] DAT_KEY2 = 8'h55;
  localparam logic [CMP_DW-1:0] DAT_PROG = 8'hA0;
  localparam logic [CMP_DW-1:0] DAT_EXT  = 8'h80;
  localparam logic [CMP_DW-1:0] DAT_IDIN = 8'h90;
  localparam logic [CMP_DW-1:0] DAT_IDOUT = 8'hF0;
  localparam logic [CMP_DW-1:0] DAT_CHIP = 8'h10;
  localparam logic [CMP_DW-1:0] DAT_SECT = 8'h30;
  localparam logic [CMP_DW-1:0] DAT_LOCK = 8'h40;
endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CMD_N-1:0]  hit_o
);
  seq_state_e state_q, state_d;
  logic wr_ok;
  logic [CMP_AW-1:0] a_lo;
  logic [CMP_DW-1:0] d_lo;
  logic at_k1, at_k2;

  assign wr_ok = wr_en_i && !busy_i;
  assign a_lo  = wr_addr_i[CMP_AW-1:0];
  assign d_lo  = wr_data_i[CMP_DW-1:0];
  assign at_k1 = (a_lo == ADR_KEY1);
  assign at_k2 = (a_lo == ADR_KEY2);

  always_comb begin
    state_d = state_q;
    hit_o   = '0;
    if (wr_ok) begin
      state_d = ST_IDLE;
      unique case (state_q)
        ST_IDLE: begin
          if (at_k1 && d_lo == DAT_KEY1) state_d = ST_UNL1;
          else if (d_lo == DAT_IDOUT)    hit_o[C_IDOUT] = 1'b1;
        end
        ST_UNL1: if (at_k2 && d_lo == DAT_KEY2) state_d = ST_UNL2;
        ST_UNL2: begin
          if (at_k1) begin
            unique case (d_lo)
              DAT_PROG:  state_d = ST_PROG;
              DAT_EXT:   state_d = ST_EXT3;
              DAT_IDIN:  hit_o[C_IDIN] = 1'b1;
              DAT_IDOUT: hit_o[C_IDOUT] = 1'b1;
              default:   state_d = ST_IDLE;
            endcase
          end
        end
        ST_PROG: hit_o[C_PROG] = 1'b1;
        ST_EXT3: if (at_k1 && d_lo == DAT_KEY1) state_d = ST_EXT4;
        ST_EXT4: if (at_k2 && d_lo == DAT_KEY2) state_d = ST_EXT5;
        ST_EXT5: begin
          if (d_lo == DAT_SECT)               hit_o[C_SECT] = 1'b1;
          else if (at_k1 && d_lo == DAT_CHIP) hit_o[C_CHIP] = 1'b1;
          else if (at_k1 && d_lo == DAT_LOCK) hit_o[C_LOCK] = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // R11
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(state_q));
  // R2
  prog_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG && wr_ok) |=> (state_q == ST_IDLE));
  // R12
  break_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UNL1 && wr_ok && !at_k2) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/flash_cmd_out.sv
module flash_cmd_out
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CMD_N-1:0]  hit_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CMD_N-1:0]  strb_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  for (genvar g = 0; g < CMD_N; g++) begin : g_strb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) strb_o[g] <= 1'b0;
      else         strb_o[g] <= hit_i[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      data_o <= '0;
    end else if (|hit_i) begin
      addr_o <= wr_addr_i;
      data_o <= wr_data_i;
    end
  end

  // R13
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strb_o));
  // R13
  strobe_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_i) |=> (addr_o == $past(wr_addr_i)));
endmodule

// File: rtl/flash_id_mode.sv
module flash_id_mode
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h001F,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h0092
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CMD_N-1:0]  hit_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              id_mode_o,
  output logic [DATA_W-1:0] id_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             id_mode_o <= 1'b0;
    else if (hit_i[C_IDIN])  id_mode_o <= 1'b1;
    else if (hit_i[C_IDOUT]) id_mode_o <= 1'b0;
  end

  always_comb begin
    id_data_o = '0;
    if (id_mode_o) begin
      if (rd_addr_i == ADDR_W'(0))      id_data_o = MFR_CODE;
      else if (rd_addr_i == ADDR_W'(1)) id_data_o = DEV_CODE;
    end
  end

  // R6
  mode_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(id_mode_o) |-> $past(hit_i[C_IDIN]));
  // R7
  mode_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(id_mode_o) |-> $past(hit_i[C_IDOUT]));
  // R9
  id_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_mode_o |-> (id_data_o == '0));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h001F,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h0092
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              cmd_chip_erase_o,
  output logic              cmd_sector_erase_o,
  output logic              cmd_word_prog_o,
  output logic              cmd_boot_lock_o,
  output logic              cmd_id_enter_o,
  output logic              cmd_id_exit_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              id_mode_o,
  output logic [DATA_W-1:0] id_data_o
);
  logic [CMD_N-1:0] hit, strb;

  flash_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fsm (
    .clk_i, .rst_ni, .wr_en_i, .busy_i, .wr_addr_i, .wr_data_i,
    .hit_o (hit)
  );

  flash_cmd_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_out (
    .clk_i, .rst_ni, .hit_i (hit), .wr_addr_i, .wr_data_i,
    .strb_o (strb), .addr_o (cmd_addr_o), .data_o (cmd_data_o)
  );

  flash_id_mode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) i_id (
    .clk_i, .rst_ni, .hit_i (hit), .rd_addr_i,
    .id_mode_o, .id_data_o
  );

  assign cmd_chip_erase_o   = strb[C_CHIP];
  assign cmd_sector_erase_o = strb[C_SECT];
  assign cmd_word_prog_o    = strb[C_PROG];
  assign cmd_boot_lock_o    = strb[C_LOCK];
  assign cmd_id_enter_o     = strb[C_IDIN];
  assign cmd_id_exit_o      = strb[C_IDOUT];

  // R11
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (strb == '0));
  // R13
  strobe_needs_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (strb == '0));
endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
  localparam int AW = 18;
  localparam int DW = 16;
  localparam int K_NONE = -1, K_CHIP = 0, K_SECT = 1, K_PROG = 2,
                 K_LOCK = 3, K_IDIN = 4, K_IDOUT = 5;

  typedef struct {
    int          kind;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0, busy = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic chip, sect, prog, lock, idin, idout, id_mode;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_data, id_data;

  int errors = 0, checks = 0;
  bit done = 0;
  bit wr_seen = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .busy_i(busy), .rd_addr_i(rd_addr),
    .cmd_chip_erase_o(chip), .cmd_sector_erase_o(sect),
    .cmd_word_prog_o(prog), .cmd_boot_lock_o(lock),
    .cmd_id_enter_o(idin), .cmd_id_exit_o(idout),
    .cmd_addr_o(c_addr), .cmd_data_o(c_data),
    .id_mode_o(id_mode), .id_data_o(id_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: called at a negedge, returns at the following negedge
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input int kind, input string req, input bit bsy = 0);
    exp_t e;
    e.kind = kind; e.addr = a; e.data = d; e.req = req;
    q.push_back(e);
    wr_en = 1'b1; wr_addr = a; wr_data = d; busy = bsy;
    @(negedge clk);
    wr_en = 1'b0; busy = 1'b0;
  endtask

  task automatic unlock2(input string req);
    wr(18'h05555, 16'h00AA, K_NONE, req);
    wr(18'h02AAA, 16'h0055, K_NONE, req);
  endtask

  task automatic ext5(input string req);
    unlock2(req);
    wr(18'h05555, 16'h0080, K_NONE, req);
    unlock2(req);
  endtask

  always @(posedge clk) wr_seen <= wr_en && rst_ni;

  // monitor / scoreboard
  always @(negedge clk) begin
    logic [5:0] act_v;
    logic [5:0] exp_v;
    act_v = {idout, idin, lock, prog, sect, chip};
    if (rst_ni && !done) begin
      if (wr_seen) begin
        exp_t e;
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R13: strobe vector %b with empty scoreboard, expected none", act_v);
        end else begin
          e = q.pop_front();
          exp_v = (e.kind < 0) ? 6'b0 : 6'(1 << e.kind);
          check(e.req, 32'(act_v), 32'(exp_v));
          if (e.kind >= 0 && act_v == exp_v) begin
            check(e.req, 32'(c_addr), 32'(e.addr));
            check(e.req, 32'(c_data), 32'(e.data));
          end
        end
      end else if (act_v != 0) begin
        checks++; errors++;
        $display("FAIL R13: strobe vector %b without a write, expected 000000", act_v);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", {26'b0, idout, idin, lock, prog, sect, chip}, 0);
    check("R10", 32'(id_mode), 0);
    check("R10", 32'(id_data), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 upper bits on unlock cycles ignored; R2 word program
    wr(18'h3D555, 16'hFFAA, K_NONE, "R1");
    wr(18'h2AAAA, 16'h7755, K_NONE, "R1");
    wr(18'h05555, 16'h00A0, K_NONE, "R2");
    wr(18'h20ABC, 16'h1234, K_PROG, "R2");

    // R3 chip erase
    ext5("R3");
    wr(18'h05555, 16'h0010, K_CHIP, "R3");

    // R4 sector erase carries sixth-cycle address
    ext5("R4");
    wr(18'h05123, 16'h0030, K_SECT, "R4");

    // R5 boot lock
    ext5("R5");
    wr(18'h05555, 16'h0040, K_LOCK, "R5");

    // R6 id entry, R9 id reads
    unlock2("R6");
    wr(18'h05555, 16'h0090, K_IDIN, "R6");
    check("R6", 32'(id_mode), 1);
    rd_addr = 18'h0; #0.1;
    check("R9", 32'(id_data), 32'h001F);
    rd_addr = 18'h1; #0.1;
    check("R9", 32'(id_data), 32'h0092);
    rd_addr = 18'h2; #0.1;
    check("R9", 32'(id_data), 0);
    rd_addr = 18'h0;

    // R8 single exit at any address, overlapping an ID read
    wr(18'h12345, 16'h00F0, K_IDOUT, "R8");
    check("R8", 32'(id_mode), 0);
    check("R9", 32'(id_data), 0);

    // R7 three-cycle exit
    unlock2("R7");
    wr(18'h05555, 16'h0090, K_IDIN, "R7");
    unlock2("R7");
    wr(18'h05555, 16'h00F0, K_IDOUT, "R7");
    check("R7", 32'(id_mode), 0);

    // R12 broken sequence is not rechecked
    wr(18'h05555, 16'h00AA, K_NONE, "R12");
    wr(18'h05555, 16'h00AA, K_NONE, "R12");
    wr(18'h02AAA, 16'h0055, K_NONE, "R12");
    wr(18'h05555, 16'h0090, K_NONE, "R12");
    check("R12", 32'(id_mode), 0);
    wr(18'h05555, 16'h00AA, K_NONE, "R12");
    wr(18'h01234, 16'h00F0, K_NONE, "R12");
    ext5("R12");
    wr(18'h05555, 16'h0020, K_NONE, "R12");

    // R11 final write while busy is ignored, position kept
    unlock2("R11");
    wr(18'h05555, 16'h0090, K_NONE, "R11", 1);
    check("R11", 32'(id_mode), 0);
    wr(18'h05555, 16'h0090, K_IDIN, "R11");
    check("R11", 32'(id_mode), 1);
    wr(18'h00000, 16'h00F0, K_NONE, "R11", 1);
    check("R11", 32'(id_mode), 1);
    wr(18'h00000, 16'h00F0, K_IDOUT, "R11");

    repeat (3) @(negedge clk);
    check("R13", 32'(q.size()), 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule